// File: doc/BRIEF.md
# Page Write Collector and Commit Engine

This block sits behind the byte-level receiver of a two-wire serial memory. It captures the word address that the receiver decodes and gathers the data bytes that follow into a one-page staging buffer. The upper address bits select the page and the lower bits give the starting slot. Each accepted byte advances only the slot index, so a long burst wraps around inside the same page instead of running into the next one.

When the receiver reports the end-of-transaction condition, the engine checks the write-protect pin and the supply-low flag. If both allow it and at least one full byte arrived, it plays the staged bytes out to the memory array, one write strobe per cycle. During that time it holds a busy flag for a fixed number of system clocks that models the cell programming time. While busy, every new request is ignored. The pointer it exposes is the current address that later reads continue from.

Top module: `page_commit_engine`

## Requirements
- R1: An accepted byte increments only the slot bits `finalPtr[4:0]`, modulo 32. The page bits `finalPtr[12:5]` keep the value loaded from `startAddr[12:5]` until the next address load.
- R2: When more than 32 bytes arrive in one transaction, a later byte replaces the earlier byte at the same slot. Byte 33 replaces byte 1, and each slot is written at most once per commit.
- R3: A commit writes exactly the slots that received a full byte. In busy cycle k (k = 0 for the first busy cycle), the engine strobes `memWrEn` with address `{page, k}` for k from 0 to 31, and only when slot k is filled.
- R4: When `partialAtStop` is high, a `byteValid` in the same cycle as `stopPulse` is discarded. A STOP with no full byte collected starts no commit and raises no busy.
- R5: When `wpIn` is high in the STOP cycle, no write strobe is issued and busy stays low.
- R6: When `supplyLow` is high in the STOP cycle, no write strobe is issued and busy stays low.
- R7: `busy` rises in the cycle after an accepted STOP and stays high for exactly WRITE_CYCLES cycles.
- R8: While `busy` is high, `addrLoad`, `byteValid` and `stopPulse` are ignored, and `finalPtr` holds its value.
- R9: When `partialAtStop` is low, a `byteValid` in the STOP cycle is taken into the commit.
- R10: The set of filled slots empties on every address load and after every STOP. A STOP with no newly received bytes writes nothing.
- R11: After reset, `busy` and `memWrEn` are low and `finalPtr` is zero.
- R12: When `addrLoad` and `byteValid` are high in the same cycle, the address is loaded and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addrLoad | input | 1 | Pulse: load the word address and open a new transaction |
| startAddr | input | ADDR_W | Word address: page in the upper bits, slot in the low 5 bits |
| byteValid | input | 1 | Pulse: a full data byte is present |
| byteData | input | DATA_W | Received data byte |
| stopPulse | input | 1 | Pulse: end-of-transaction condition seen on the bus |
| partialAtStop | input | 1 | The byte in progress at STOP was incomplete |
| wpIn | input | 1 | Write-protect level, sampled at STOP |
| supplyLow | input | 1 | Supply-low flag, sampled at STOP |
| busy | output | 1 | Commit and programming interval in progress |
| memWrEn | output | 1 | Memory array write strobe |
| memWrAddr | output | ADDR_W | Memory array write address |
| memWrData | output | DATA_W | Memory array write data |
| finalPtr | output | ADDR_W | Current address pointer |

## Verification
The bench starts a burst two slots before the end of the last page. A design that carried into the page bits would write outside the page and report a wrong pointer. A 33-byte burst checks that the first slot ends up holding the newest value and gets only one strobe; a design that kept a byte count instead of a slot set would issue 33 strobes or keep the stale byte. STOP is also driven with protection, with low supply, with a truncated first byte, with a truncated trailing byte, with a coincident full byte, and with no new data after a cancelled commit. A design that left the slot set uncleared, or that merged the truncated byte, would write locations that must stay untouched. Requests issued during busy and a load that collides with a byte show whether the design leaks inputs into the pointer or the buffer.

// File: rtl/pce_pkg.sv
package pce_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadAddr;   // capture page and slot from startAddr
    logic takeByte;   // store byteData at the current slot, advance slot
    logic clearMask;  // forget every filled slot
    logic scanEn;     // commit scan is presenting a slot this cycle
  } pce_ctrl_t;
endpackage

// File: rtl/pce_control.sv
module pce_control
  import pce_pkg::*;
#(
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 2500000
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          addrLoad,
  input  logic                          byteValid,
  input  logic                          stopPulse,
  input  logic                          partialAtStop,
  input  logic                          wpIn,
  input  logic                          supplyLow,
  input  logic                          maskAny,
  output pce_ctrl_t                     ctrl,
  output logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  output logic                          busy
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int SPAN   = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;
  localparam int CNT_W  = $clog2(SPAN + 1);

  typedef enum logic {ST_IDLE, ST_BUSY} state_t;

  state_t           state;
  logic [CNT_W-1:0] cycCnt;
  logic             accepting;
  logic             stopSeen;
  logic             commitGo;
  logic             lastCyc;

  always_comb begin
    accepting     = (state == ST_IDLE);
    ctrl.loadAddr = accepting && addrLoad;
    ctrl.takeByte = accepting && !addrLoad && byteValid && !(stopPulse && partialAtStop);
    stopSeen      = accepting && !addrLoad && stopPulse;
    commitGo      = stopSeen && (maskAny || ctrl.takeByte) && !wpIn && !supplyLow;
    lastCyc       = (state == ST_BUSY) && (cycCnt == CNT_W'(WRITE_CYCLES - 1));
    ctrl.clearMask = ctrl.loadAddr || (stopSeen && !commitGo) || lastCyc;
    ctrl.scanEn   = (state == ST_BUSY) && (cycCnt < CNT_W'(PAGE_BYTES));
    scanIdx       = cycCnt[OFF_W-1:0];
    busy          = (state == ST_BUSY);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cycCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (commitGo) begin
            state  <= ST_BUSY;
            cycCnt <= '0;
          end
        end
        ST_BUSY: begin
          if (lastCyc) begin
            state  <= ST_IDLE;
            cycCnt <= '0;
          end else begin
            cycCnt <= cycCnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pce_datapath.sv
module pce_datapath
  import pce_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  pce_ctrl_t                     ctrl,
  input  logic [$clog2(PAGE_BYTES)-1:0] scanIdx,
  input  logic [ADDR_W-1:0]             startAddr,
  input  logic [DATA_W-1:0]             byteData,
  output logic                          maskAny,
  output logic                          memWrEn,
  output logic [ADDR_W-1:0]             memWrAddr,
  output logic [DATA_W-1:0]             memWrData,
  output logic [ADDR_W-1:0]             finalPtr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0]     pageReg;
  logic [OFF_W-1:0]      offReg;
  logic [PAGE_BYTES-1:0] fillMask;
  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];

  // Pointer: page fixed per transaction, slot wraps inside the page
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg <= '0;
      offReg  <= '0;
    end else if (ctrl.loadAddr) begin
      pageReg <= startAddr[ADDR_W-1:OFF_W];
      offReg  <= startAddr[OFF_W-1:0];
    end else if (ctrl.takeByte) begin
      offReg  <= offReg + OFF_W'(1);
    end
  end

  // Per-slot fill flag and staging byte
  for (genvar gi = 0; gi < PAGE_BYTES; gi++) begin : g_slot
    logic hit;
    assign hit = ctrl.takeByte && (offReg == OFF_W'(gi));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               fillMask[gi] <= 1'b0;
      else if (ctrl.clearMask) fillMask[gi] <= 1'b0;
      else if (hit)            fillMask[gi] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (hit) pageBuf[gi] <= byteData;
    end
  end

  always_comb begin
    maskAny   = |fillMask;
    memWrEn   = ctrl.scanEn && fillMask[scanIdx];
    memWrAddr = {pageReg, scanIdx};
    memWrData = pageBuf[scanIdx];
    finalPtr  = {pageReg, offReg};
  end
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine
  import pce_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 2500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stopPulse,
  input  logic              partialAtStop,
  input  logic              wpIn,
  input  logic              supplyLow,
  output logic              busy,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] finalPtr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  pce_ctrl_t        ctrl;
  logic [OFF_W-1:0] scanIdx;
  logic             maskAny;

  pce_control #(
    .PAGE_BYTES  (PAGE_BYTES),
    .WRITE_CYCLES(WRITE_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .addrLoad     (addrLoad),
    .byteValid    (byteValid),
    .stopPulse    (stopPulse),
    .partialAtStop(partialAtStop),
    .wpIn         (wpIn),
    .supplyLow    (supplyLow),
    .maskAny      (maskAny),
    .ctrl         (ctrl),
    .scanIdx      (scanIdx),
    .busy         (busy)
  );

  pce_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .scanIdx  (scanIdx),
    .startAddr(startAddr),
    .byteData (byteData),
    .maskAny  (maskAny),
    .memWrEn  (memWrEn),
    .memWrAddr(memWrAddr),
    .memWrData(memWrData),
    .finalPtr (finalPtr)
  );
endmodule

// File: rtl/page_commit_engine_checker.sv
module page_commit_engine_checker #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_BYTES   = 32,
  parameter int WRITE_CYCLES = 2500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic              byteValid,
  input logic              stopPulse,
  input logic              partialAtStop,
  input logic              wpIn,
  input logic              supplyLow,
  input logic              busy,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memWrAddr,
  input logic [ADDR_W-1:0] finalPtr
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int CW    = $clog2(WRITE_CYCLES + 2);

  logic [CW-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + CW'(1);
    else           busyRun <= '0;
  end

  assert_strobe_in_busy_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> busy);

  assert_strobe_same_page_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memWrAddr[ADDR_W-1:OFF_W] == finalPtr[ADDR_W-1:OFF_W]));

  assert_page_fixed_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && byteValid && !addrLoad) |=>
      (finalPtr[ADDR_W-1:OFF_W] == $past(finalPtr[ADDR_W-1:OFF_W])));

  assert_wp_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopPulse && wpIn) |=> !busy);

  assert_low_supply_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopPulse && supplyLow) |=> !busy);

  assert_commit_starts_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopPulse && !addrLoad && byteValid && !partialAtStop && !wpIn && !supplyLow)
      |=> busy);

  assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyRun == CW'(WRITE_CYCLES)));

  assert_ptr_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(finalPtr));
endmodule

bind page_commit_engine page_commit_engine_checker #(
  .ADDR_W      (ADDR_W),
  .PAGE_BYTES  (PAGE_BYTES),
  .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .addrLoad     (addrLoad),
  .byteValid    (byteValid),
  .stopPulse    (stopPulse),
  .partialAtStop(partialAtStop),
  .wpIn         (wpIn),
  .supplyLow    (supplyLow),
  .busy         (busy),
  .memWrEn      (memWrEn),
  .memWrAddr    (memWrAddr),
  .finalPtr     (finalPtr)
);

// File: tb/page_commit_engine_tb.sv
module page_commit_engine_tb;
  localparam int WR = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        addrLoad = 1'b0;
  logic [12:0] startAddr = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        stopPulse = 1'b0;
  logic        partialAtStop = 1'b0;
  logic        wpIn = 1'b0;
  logic        supplyLow = 1'b0;
  logic        busy, memWrEn;
  logic [12:0] memWrAddr, finalPtr;
  logic [7:0]  memWrData;

  always #2 clk = ~clk;

  page_commit_engine #(.WRITE_CYCLES(WR)) u_dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .stopPulse(stopPulse),
    .partialAtStop(partialAtStop), .wpIn(wpIn), .supplyLow(supplyLow),
    .busy(busy), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .finalPtr(finalPtr)
  );

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  logic [7:0] shadow [int];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  int         mPage = 0, mOff = 0, mCyc = 0;
  bit         mBusy = 0;
  logic [7:0] mBytes [int];
  logic [7:0] mCommit [int];

  always @(posedge clk) begin
    if (!rstN) begin
      mPage = 0; mOff = 0; mBusy = 0; mCyc = 0;
      mBytes.delete(); mCommit.delete();
    end else if (mBusy) begin
      mCyc++;
      if (mCyc == WR) mBusy = 0;
    end else if (addrLoad) begin
      mPage = int'(startAddr) / 32;
      mOff  = int'(startAddr) % 32;
      mBytes.delete();
    end else begin
      if (byteValid && !(stopPulse && partialAtStop)) begin
        mBytes[mOff] = byteData;
        mOff = (mOff + 1) % 32;
      end
      if (stopPulse) begin
        if (mBytes.num() > 0 && !wpIn && !supplyLow) begin
          mBusy = 1; mCyc = 0; mCommit = mBytes;
        end
        mBytes.delete();
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      bit expWe;
      expWe = mBusy && mCyc < 32 && mCommit.exists(mCyc);
      chk("R7 busy", int'(busy), int'(mBusy));
      chk("R3 strobe", int'(memWrEn), int'(expWe));
      chk("R1 pointer", int'(finalPtr), mPage * 32 + mOff);
      if (expWe) begin
        chk("R3 address", int'(memWrAddr), mPage * 32 + mCyc);
        chk("R3 data", int'(memWrData), int'(mCommit[mCyc]));
      end
      if (memWrEn) begin
        shadow[int'(memWrAddr)] = memWrData;
        wrCount++;
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask
  task automatic doLoad(int a);
    addrLoad = 1'b1; startAddr = 13'(a); step(); addrLoad = 1'b0;
  endtask
  task automatic doByte(int d);
    byteValid = 1'b1; byteData = 8'(d); step(); byteValid = 1'b0;
  endtask
  task automatic doStop(bit part, bit withByte, int d);
    stopPulse = 1'b1; partialAtStop = part; byteValid = withByte; byteData = 8'(d);
    step();
    stopPulse = 1'b0; partialAtStop = 1'b0; byteValid = 1'b0;
  endtask
  task automatic waitIdle();
    while (busy) step();
  endtask
  function automatic int shadowAt(int a);
    return shadow.exists(a) ? int'(shadow[a]) : -1;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    checks++; errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    int base;
    step(); step();
    // R11: reset state
    chk("R11 busy", int'(busy), 0);
    chk("R11 strobe", int'(memWrEn), 0);
    chk("R11 pointer", int'(finalPtr), 0);
    rstN = 1'b1;
    step();

    // R3 / R7: single byte
    doLoad(13'h0123); doByte(8'hA5); doStop(0, 0, 0);
    chk("R7 busy after stop", int'(busy), 1);
    waitIdle();
    chk("R3 single byte", shadowAt(13'h0123), 8'hA5);
    chk("R3 strobe count", wrCount, 1);
    chk("R1 pointer after byte", int'(finalPtr), 13'h0124);

    // R1: wrap inside the last page
    doLoad(13'h1FFE);
    doByte(8'h11); doByte(8'h22); doByte(8'h33); doByte(8'h44);
    doStop(0, 0, 0); waitIdle();
    chk("R1 slot 30", shadowAt(13'h1FFE), 8'h11);
    chk("R1 slot 31", shadowAt(13'h1FFF), 8'h22);
    chk("R1 slot 0 wrap", shadowAt(13'h1FE0), 8'h33);
    chk("R1 slot 1 wrap", shadowAt(13'h1FE1), 8'h44);
    chk("R1 wrapped pointer", int'(finalPtr), 13'h1FE2);

    // R2: 33 bytes, the last replaces the first
    base = wrCount;
    doLoad(13'h0040);
    for (int i = 0; i < 33; i++) doByte(i + 1);
    doStop(0, 0, 0); waitIdle();
    chk("R2 overwritten slot", shadowAt(13'h0040), 33);
    chk("R2 second slot", shadowAt(13'h0041), 2);
    chk("R2 strobe count", wrCount - base, 32);

    // R5: write protect
    base = wrCount;
    wpIn = 1'b1;
    doLoad(13'h0200); doByte(8'h01); doByte(8'h02); doStop(0, 0, 0);
    step(); step();
    chk("R5 busy", int'(busy), 0);
    chk("R5 strobes", wrCount - base, 0);
    wpIn = 1'b0;

    // R6: supply low
    supplyLow = 1'b1;
    doLoad(13'h0300); doByte(8'h05); doStop(0, 1, 8'h06);
    step(); step();
    chk("R6 busy", int'(busy), 0);
    chk("R6 strobes", wrCount - base, 0);
    supplyLow = 1'b0;

    // R10: bare STOP after a cancelled commit
    doStop(0, 0, 0); step(); step();
    chk("R10 busy", int'(busy), 0);
    chk("R10 strobes", wrCount - base, 0);

    // R4: truncated first byte aborts
    doLoad(13'h0400); doStop(1, 1, 8'h77); step(); step();
    chk("R4 abort busy", int'(busy), 0);
    chk("R4 abort strobes", wrCount - base, 0);

    // R4: truncated trailing byte dropped, earlier bytes kept
    doLoad(13'h0500); doByte(8'h5A); doByte(8'h6B); doStop(1, 1, 8'h7C);
    waitIdle();
    chk("R4 kept slot 0", shadowAt(13'h0500), 8'h5A);
    chk("R4 kept slot 1", shadowAt(13'h0501), 8'h6B);
    chk("R4 dropped slot", shadowAt(13'h0502), -1);
    chk("R4 pointer", int'(finalPtr), 13'h0502);

    // R9: full byte at STOP is committed
    doLoad(13'h0600); doByte(8'h01); doStop(0, 1, 8'h02); waitIdle();
    chk("R9 first", shadowAt(13'h0600), 8'h01);
    chk("R9 coincident", shadowAt(13'h0601), 8'h02);

    // R8: requests while busy are ignored
    base = wrCount;
    doLoad(13'h0700); doByte(8'h99); doStop(0, 0, 0);
    addrLoad = 1'b1; startAddr = '0; step(); addrLoad = 1'b0;
    doByte(8'hEE); doStop(0, 1, 8'hEF);
    chk("R8 pointer held", int'(finalPtr), 13'h0701);
    waitIdle(); step(); step();
    chk("R8 no stray write", shadowAt(0), -1);
    chk("R8 strobe count", wrCount - base, 1);
    chk("R8 committed", shadowAt(13'h0700), 8'h99);

    // R12: load wins over a byte in the same cycle
    base = wrCount;
    addrLoad = 1'b1; startAddr = 13'h0800; byteValid = 1'b1; byteData = 8'hFF;
    step(); addrLoad = 1'b0; byteValid = 1'b0;
    chk("R12 pointer", int'(finalPtr), 13'h0800);
    doByte(8'h10); doStop(0, 0, 0); waitIdle();
    chk("R12 slot value", shadowAt(13'h0800), 8'h10);
    chk("R12 strobe count", wrCount - base, 1);

    step(); step();
    finishRun();
  end
endmodule